// File: doc/BRIEF.md
# Test pin override multiplexer

This block holds one global 32-bit test-control word, written from a microprocessor bus. The word decides what drives a bank of chip output pins. In normal operation each pin carries its functional signal: the interrupt, the sync output, the serial clock, the sync of each of four channels and the first serial data output of each channel. When the master override bit is set, fixed bits of the word drive those pins as static levels, so that board interconnects can be checked one net at a time.

The serial clock pin is a special case. It takes its override level only when a divided-down serial clock is selected elsewhere. With the undivided clock selected, the pin keeps running. The word also has one select per channel that puts the sign bit (MSB) of that channel's carrier sine onto the channel's second serial data output. A further three bits are passed out as enables for data-RAM test access, internal test mode and self-test. The functional sources are ports of the block. A read returns the last word written.

Top module: `test_pin_override`

## Requirements
- R1: After reset the word is all zeros, `cfg_rdata_o` reads 0, every pin carries its functional input and the three test enables are 0.
- R2: A cycle with `cfg_we_i` high stores all 32 bits of `cfg_wdata_i`. `cfg_rdata_o` returns them from the next cycle on, and this includes unused bits.
- R3: While bit 16 of the word is 0, the interrupt, sync-out, per-channel sync and per-channel serial data 1 pins follow their functional inputs, whatever bits 31:17 hold.
- R4: While bit 16 is 1, the pins take these levels: interrupt = bit 31, sync-out = bit 30, sync of channel k = bit 28-k, serial data 1 of channel k = bit 24-k (k = 0..3). The levels appear in the cycle after the write.
- R5: The serial clock pin equals bit 29 only while bit 16 is 1 and `sclk_div_sel_i` is 1. In every other case it equals `sclk_i`.
- R6: Bit 7-k set puts `ch_sin_msb_i[k]` on `ch_sd2_pin_o[k]`. Bit 7-k clear leaves `ch_sd2_i[k]` there. This does not depend on bit 16.
- R7: `dram_test_o` equals bit 15, `int_test_o` equals bit 1 and `self_test_o` equals bit 0.
- R8: Bits 14:8 and 3:2, and bits 20:17 at any time, change no output pin or enable.
- R9: While `cfg_we_i` is low the stored word, and so every override, does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write strobe for the test-control word |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Stored word |
| sclk_div_sel_i | input | 1 | 1 = divided serial clock selected, 0 = undivided clock |
| irq_i | input | 1 | Functional interrupt |
| sync_out_i | input | 1 | Functional sync output |
| sclk_i | input | 1 | Functional serial clock |
| ch_sync_i | input | 4 | Functional sync per channel (bit k = channel k) |
| ch_sd1_i | input | 4 | Functional serial data 1 per channel |
| ch_sd2_i | input | 4 | Functional serial data 2 per channel |
| ch_sin_msb_i | input | 4 | Carrier sine MSB per channel |
| irq_pin_o | output | 1 | Interrupt pin |
| sync_out_pin_o | output | 1 | Sync-out pin |
| sclk_pin_o | output | 1 | Serial clock pin |
| ch_sync_pin_o | output | 4 | Sync pins per channel |
| ch_sd1_pin_o | output | 4 | Serial data 1 pins per channel |
| ch_sd2_pin_o | output | 4 | Serial data 2 pins per channel |
| dram_test_o | output | 1 | Data-RAM test access enable |
| int_test_o | output | 1 | Internal test mode |
| self_test_o | output | 1 | Self-test mode |

## Verification
The bench goes after the serial clock gating: overriding with the undivided clock selected would freeze a running clock, and ignoring the select would never let the pin be driven. It walks one override bit at a time. A reversed channel order, where bit 28 lands on channel 3, shows up as the wrong pin rising. It writes all ones to the unused bits with the override off, so that a decode that leaks bits 20:17 or 14:8 is caught. It also toggles the sine selects with the override both on and off, which catches sine routing that is wrongly gated by bit 16.

// File: rtl/test_pin_pkg.sv
package test_pin_pkg;
  localparam int unsigned CFG_W  = 32;
  localparam int unsigned NUM_CH = 4;

  // bit positions consumed by the pin decode
  localparam int unsigned OVR_EN_BIT = 16;
  localparam int unsigned IRQ_BIT    = 31;
  localparam int unsigned SYNCO_BIT  = 30;
  localparam int unsigned SCLK_BIT   = 29;
  localparam int unsigned SYNC_TOP   = 28;  // channel k at SYNC_TOP-k
  localparam int unsigned SD1_TOP    = 24;  // channel k at SD1_TOP-k
  localparam int unsigned SIN_TOP    = 7;   // channel k at SIN_TOP-k
  localparam int unsigned DRAM_BIT   = 15;
  localparam int unsigned INT_BIT    = 1;
  localparam int unsigned SELF_BIT   = 0;

  typedef struct packed {
    logic              ovr_en;
    logic              ovr_irq;
    logic              ovr_synco;
    logic              ovr_sclk;
    logic [NUM_CH-1:0] ovr_sync;
    logic [NUM_CH-1:0] ovr_sd1;
    logic [NUM_CH-1:0] sin_sel;
    logic              dram_test;
    logic              int_test;
    logic              self_test;
  } tst_ctl_t;
endpackage

// File: rtl/tst_cfg_reg.sv
module tst_cfg_reg
  import test_pin_pkg::*;
#(
  parameter int unsigned W = CFG_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= wdata_i;
  end

  a_r2_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> q_o == $past(wdata_i));
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/tst_cfg_decode.sv
module tst_cfg_decode
  import test_pin_pkg::*;
(
  input  logic [CFG_W-1:0] word_i,
  output tst_ctl_t         ctl_o
);
  always_comb begin
    ctl_o           = '0;
    ctl_o.ovr_en    = word_i[OVR_EN_BIT];
    ctl_o.ovr_irq   = word_i[IRQ_BIT];
    ctl_o.ovr_synco = word_i[SYNCO_BIT];
    ctl_o.ovr_sclk  = word_i[SCLK_BIT];
    ctl_o.dram_test = word_i[DRAM_BIT];
    ctl_o.int_test  = word_i[INT_BIT];
    ctl_o.self_test = word_i[SELF_BIT];
    // per-channel fields count downward from their top bit
    for (int k = 0; k < NUM_CH; k++) begin
      ctl_o.ovr_sync[k] = word_i[SYNC_TOP-k];
      ctl_o.ovr_sd1[k]  = word_i[SD1_TOP-k];
      ctl_o.sin_sel[k]  = word_i[SIN_TOP-k];
    end
  end
endmodule

// File: rtl/tst_pin_mux.sv
module tst_pin_mux
  import test_pin_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  tst_ctl_t          ctl_i,
  input  logic              sclk_div_sel_i,
  input  logic              irq_i,
  input  logic              sync_out_i,
  input  logic              sclk_i,
  input  logic [NUM_CH-1:0] ch_sync_i,
  input  logic [NUM_CH-1:0] ch_sd1_i,
  input  logic [NUM_CH-1:0] ch_sd2_i,
  input  logic [NUM_CH-1:0] ch_sin_msb_i,
  output logic              irq_pin_o,
  output logic              sync_out_pin_o,
  output logic              sclk_pin_o,
  output logic [NUM_CH-1:0] ch_sync_pin_o,
  output logic [NUM_CH-1:0] ch_sd1_pin_o,
  output logic [NUM_CH-1:0] ch_sd2_pin_o
);
  logic sclk_ovr;
  // an undivided clock cannot be parked on a static level
  assign sclk_ovr       = ctl_i.ovr_en & sclk_div_sel_i;
  assign irq_pin_o      = ctl_i.ovr_en ? ctl_i.ovr_irq   : irq_i;
  assign sync_out_pin_o = ctl_i.ovr_en ? ctl_i.ovr_synco : sync_out_i;
  assign sclk_pin_o     = sclk_ovr     ? ctl_i.ovr_sclk  : sclk_i;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    assign ch_sync_pin_o[k] = ctl_i.ovr_en ? ctl_i.ovr_sync[k] : ch_sync_i[k];
    assign ch_sd1_pin_o[k]  = ctl_i.ovr_en ? ctl_i.ovr_sd1[k]  : ch_sd1_i[k];
    assign ch_sd2_pin_o[k]  = ctl_i.sin_sel[k] ? ch_sin_msb_i[k] : ch_sd2_i[k];
  end

  a_r3_functional: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_i.ovr_en |-> (irq_pin_o == irq_i) && (sync_out_pin_o == sync_out_i)
                   && (ch_sync_pin_o == ch_sync_i) && (ch_sd1_pin_o == ch_sd1_i));
  a_r5_sclk_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sclk_div_sel_i |-> sclk_pin_o == sclk_i);
  a_r6_sin_route: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ch_sd2_pin_o ^ ch_sin_msb_i) & ctl_i.sin_sel) == '0);
endmodule

// File: rtl/test_pin_override.sv
module test_pin_override
  import test_pin_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  output logic [CFG_W-1:0]  cfg_rdata_o,
  input  logic              sclk_div_sel_i,
  input  logic              irq_i,
  input  logic              sync_out_i,
  input  logic              sclk_i,
  input  logic [NUM_CH-1:0] ch_sync_i,
  input  logic [NUM_CH-1:0] ch_sd1_i,
  input  logic [NUM_CH-1:0] ch_sd2_i,
  input  logic [NUM_CH-1:0] ch_sin_msb_i,
  output logic              irq_pin_o,
  output logic              sync_out_pin_o,
  output logic              sclk_pin_o,
  output logic [NUM_CH-1:0] ch_sync_pin_o,
  output logic [NUM_CH-1:0] ch_sd1_pin_o,
  output logic [NUM_CH-1:0] ch_sd2_pin_o,
  output logic              dram_test_o,
  output logic              int_test_o,
  output logic              self_test_o
);
  logic [CFG_W-1:0] word_q;
  tst_ctl_t         ctl;

  tst_cfg_reg #(.W(CFG_W)) i_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i),
    .wdata_i(cfg_wdata_i), .q_o(word_q)
  );

  tst_cfg_decode i_dec (.word_i(word_q), .ctl_o(ctl));

  tst_pin_mux i_mux (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctl_i(ctl),
    .sclk_div_sel_i(sclk_div_sel_i),
    .irq_i(irq_i), .sync_out_i(sync_out_i), .sclk_i(sclk_i),
    .ch_sync_i(ch_sync_i), .ch_sd1_i(ch_sd1_i), .ch_sd2_i(ch_sd2_i),
    .ch_sin_msb_i(ch_sin_msb_i),
    .irq_pin_o(irq_pin_o), .sync_out_pin_o(sync_out_pin_o),
    .sclk_pin_o(sclk_pin_o), .ch_sync_pin_o(ch_sync_pin_o),
    .ch_sd1_pin_o(ch_sd1_pin_o), .ch_sd2_pin_o(ch_sd2_pin_o)
  );

  assign cfg_rdata_o = word_q;
  assign dram_test_o = ctl.dram_test;
  assign int_test_o  = ctl.int_test;
  assign self_test_o = ctl.self_test;

  a_r4_irq_ovr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && cfg_wdata_i[OVR_EN_BIT] |=> irq_pin_o == $past(cfg_wdata_i[IRQ_BIT]));
  a_r4_sync0_ovr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && cfg_wdata_i[OVR_EN_BIT] |=> ch_sync_pin_o[0] == $past(cfg_wdata_i[SYNC_TOP]));
  a_r7_self_test: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> self_test_o == $past(cfg_wdata_i[SELF_BIT]));
endmodule

// File: tb/test_test_pin_override.sv
module test_test_pin_override;
  logic        clk_i = 0, rst_ni = 0;
  logic        cfg_we_i = 0;
  logic [31:0] cfg_wdata_i = 0, cfg_rdata_o;
  logic        sclk_div_sel_i = 0, irq_i = 0, sync_out_i = 0, sclk_i = 0;
  logic [3:0]  ch_sync_i = 0, ch_sd1_i = 0, ch_sd2_i = 0, ch_sin_msb_i = 0;
  logic        irq_pin_o, sync_out_pin_o, sclk_pin_o;
  logic [3:0]  ch_sync_pin_o, ch_sd1_pin_o, ch_sd2_pin_o;
  logic        dram_test_o, int_test_o, self_test_o;

  int total = 0, bad = 0;
  logic [31:0] shadow = 0;

  always #2.5 clk_i = ~clk_i;

  test_pin_override i_test_pin_override (.*);

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog: run hung");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected pin levels from the requirements
  function automatic logic [3:0] ovr_ch(logic [31:0] w, int top);
    logic [3:0] r;
    for (int k = 0; k < 4; k++) r[k] = w[top-k];
    return r;
  endfunction

  task automatic check_all(string tag);
    logic ov = shadow[16];
    chk({tag, " R2 rdata"}, cfg_rdata_o, shadow);
    chk({tag, " R3/R4 irq"}, irq_pin_o, ov ? shadow[31] : irq_i);
    chk({tag, " R3/R4 sync_out"}, sync_out_pin_o, ov ? shadow[30] : sync_out_i);
    chk({tag, " R5 sclk"}, sclk_pin_o, (ov && sclk_div_sel_i) ? shadow[29] : sclk_i);
    chk({tag, " R3/R4 sync"}, ch_sync_pin_o, ov ? ovr_ch(shadow, 28) : ch_sync_i);
    chk({tag, " R3/R4 sd1"}, ch_sd1_pin_o, ov ? ovr_ch(shadow, 24) : ch_sd1_i);
    begin
      logic [3:0] s = ovr_ch(shadow, 7);
      chk({tag, " R6 sd2"}, ch_sd2_pin_o, (ch_sin_msb_i & s) | (ch_sd2_i & ~s));
    end
    chk({tag, " R7 enables"}, {dram_test_o, int_test_o, self_test_o},
        {shadow[15], shadow[1], shadow[0]});
  endtask

  task automatic rand_inputs();
    logic [31:0] r = $urandom;
    {irq_i, sync_out_i, sclk_i} = r[2:0];
    ch_sync_i = r[7:4]; ch_sd1_i = r[11:8];
    ch_sd2_i = r[15:12]; ch_sin_msb_i = r[19:16];
  endtask

  // drive at negedge, commit at posedge, check 1 ns later
  task automatic step(logic we, logic [31:0] d, string tag);
    @(negedge clk_i);
    cfg_we_i = we; cfg_wdata_i = d;
    @(posedge clk_i);
    if (we) shadow = d;
    #1;
    check_all(tag);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    rand_inputs();
    #1;
    check_all("R1 in reset");
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    step(0, 0, "R1 after reset");

    // R4: each override bit alone
    for (int b = 21; b <= 31; b++) begin
      step(1, (32'h1 << 16) | (32'h1 << b), "R4 walk");
      sclk_div_sel_i = 1; #0.5;
      check_all("R5 div sel");
    end
    // R5: undivided clock keeps running under override
    sclk_div_sel_i = 0;
    step(1, 32'hFFFF_0000, "R5 x1 clock");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i); sclk_i = ~sclk_i; #0.5;
      chk("R5 sclk follows clock", sclk_pin_o, sclk_i);
    end
    // R8: unused bits with override off
    step(1, 32'hFFFE_7F0C & ~32'h0001_0000, "R8 unused");
    chk("R8 no enable leak", {dram_test_o, int_test_o, self_test_o}, 3'b000);
    // R6: sine selects, override on and off
    for (int k = 0; k < 4; k++) begin
      rand_inputs();
      step(1, 32'h1 << (7 - k), "R6 sel off-ovr");
      step(1, (32'h1 << (7 - k)) | 32'h0001_0000, "R6 sel on-ovr");
    end
    // R7
    step(1, 32'h0000_8003, "R7 enables");
    // R9: hold with random write data
    for (int i = 0; i < 8; i++) begin
      rand_inputs();
      step(0, $urandom, "R9 hold");
    end
    // random mix
    for (int i = 0; i < 400; i++) begin
      rand_inputs();
      sclk_div_sel_i = $urandom_range(0, 1);
      step(($urandom_range(0, 1) == 1), $urandom, "rand");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule